// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block produces the active-low system reset for a processor board from three causes. The causes are a digital indication that the supply is below its trip level, early and late fault pulses from a watchdog, and a manual reset switch. The switch is wired to the same pin that the block drives low. The block never releases the reset the moment a cause goes away. It keeps the pin low for a fixed number of ticks of a 1 ms enable, which lets the supply settle and absorbs switch bounce.

The pin level comes back through a synchronizer. A falling edge that the block did not cause itself starts a new stretched pulse. A lockout output tells the serial interface to refuse new commands while the block drives reset. A transaction that was already running when the reset began is allowed to finish before the lockout takes hold. Three sticky flags record whether a reset came from the supply, an early watchdog fault or a late watchdog fault. A manual reset leaves all three clear, which is how it is told apart. Software clears each flag by writing a zero to its bit.

Top module: `sup_rst_gen`

## Requirements
- R1: After `rst_n` is released, `pin_drive_low` and `bus_lockout` are 1 and `reg_rdata` is 8'h00; the drive is released after HOLD_TICKS ticks, as in R3.
- R2: While `supply_low` is 1, `pin_drive_low` is 1 from the following clock cycle on, however many ticks pass.
- R3: Once the last cause has gone away, `pin_drive_low` stays 1 until HOLD_TICKS cycles with `tick_ms` high have been seen. It falls in the cycle after the last of those ticks.
- R4: A high-to-low change of `pin_sense` while the block is not driving sets `pin_drive_low` on the third rising clock edge after the change: two edges of synchronizer and one edge of pulse register.
- R5: The low level that the block's own drive puts on the pin never starts a further pulse; after a pulse ends the drive stays 0.
- R6: If the pin is still held low from outside when a manual pulse ends, `pin_drive_low` and `bus_lockout` both go to 0 and stay 0.
- R7: A one-cycle early or late watchdog fault pulse sets `pin_drive_low` on the next edge.
- R8: The status byte on `reg_rdata` has the early-watchdog flag at bit 7, the late-watchdog flag at bit 6 and the supply flag at bit 5, with bits 4..0 always 0. A supply-low cycle sets bit 5, and each watchdog pulse sets its own bit. A manual reset sets none of them.
- R9: A write with `reg_wr` high clears every flag whose bit in `reg_wdata` is 0 and leaves the flags whose bit is 1 unchanged. A set event in the same cycle as a clearing write wins.
- R10: A new cause during an active pulse restarts the count, so HOLD_TICKS further ticks are needed from that point.
- R11: `bus_lockout` is 1 only while `pin_drive_low` is 1. If `bus_busy` is 1 when a pulse starts, the lockout rises on the edge after `bus_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_ms | input | 1 | One-cycle enable, once per millisecond |
| supply_low | input | 1 | Supply below trip level (synchronous) |
| wdt_early_flt | input | 1 | Watchdog kicked too early, one-cycle pulse |
| wdt_late_flt | input | 1 | Watchdog not kicked in time, one-cycle pulse |
| pin_sense | input | 1 | Sensed level of the bidirectional reset pin |
| bus_busy | input | 1 | Serial transaction in progress |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| reg_rdata | output | 8 | Status register read value |
| pin_drive_low | output | 1 | Pull the reset pin low |
| bus_lockout | output | 1 | Refuse new serial commands |

## Verification
The bench builds the block with HOLD_TICKS set to 4 and a two-stage synchronizer, and it drives `tick_ms` by hand. With the short hold, the bench can check the exact release edge, the cycle before it, and restarts partway through a pulse, all in a few hundred cycles. The pin is modelled as a wired-low of the block's drive and an external switch. This lets the bench cover self-retrigger masking, a switch held low past the end of a pulse, and the exact three-edge latency of manual detection.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_EWD  = 7;
  localparam int BIT_LWD  = 6;
  localparam int BIT_SUP  = 5;

  typedef struct packed {
    logic early;
    logic late;
    logic supply;
  } rst_src_t;
endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic own_drive,
  output logic man_trig
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic [STAGES-1:0] hist_q, hist_d;
  logic              prev_q, prev_d;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
    hist_d = {hist_q[STAGES-2:0], own_drive};
    prev_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '1;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
      prev_q <= prev_d;
    end
  end

  // falling edge not caused by this block's own drive
  assign man_trig = prev_q & ~cur & ~own_drive & ~(|hist_q);
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int HOLD_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  input  logic trig,
  output logic active,
  output logic active_nxt
);
  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (hold || trig) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q && tick) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active     = act_q;
  assign active_nxt = act_d;
endmodule

// File: rtl/rst_src_flags.sv
module rst_src_flags
  import sup_rst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  rst_src_t         set_ev,
  input  logic             wr,
  input  rst_src_t         wr_bits,
  output logic [STAT_W-1:0] stat
);
  rst_src_t flg_q, flg_d, keep;

  always_comb begin
    keep  = wr ? wr_bits : '1;
    flg_d = (flg_q & keep) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  always_comb begin
    stat          = '0;
    stat[BIT_EWD] = flg_q.early;
    stat[BIT_LWD] = flg_q.late;
    stat[BIT_SUP] = flg_q.supply;
  end
endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen
  import sup_rst_pkg::*;
#(
  parameter int HOLD_TICKS  = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              supply_low,
  input  logic              wdt_early_flt,
  input  logic              wdt_late_flt,
  input  logic              pin_sense,
  input  logic              bus_busy,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              pin_drive_low,
  output logic              bus_lockout
);
  logic     man_trig, drv_q, drv_nxt, trig_any;
  logic     lock_q, lock_d;
  rst_src_t set_ev, wr_bits;
  logic     unused_wbits;

  assign unused_wbits = ^reg_wdata[BIT_SUP-1:0];

  rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (pin_sense),
    .own_drive(drv_q),
    .man_trig (man_trig)
  );

  assign trig_any = man_trig | wdt_early_flt | wdt_late_flt;

  rst_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_stretch (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_ms),
    .hold      (supply_low),
    .trig      (trig_any),
    .active    (drv_q),
    .active_nxt(drv_nxt)
  );

  always_comb begin
    set_ev.early   = wdt_early_flt;
    set_ev.late    = wdt_late_flt;
    set_ev.supply  = supply_low;
    wr_bits.early  = reg_wdata[BIT_EWD];
    wr_bits.late   = reg_wdata[BIT_LWD];
    wr_bits.supply = reg_wdata[BIT_SUP];
  end

  rst_src_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (set_ev),
    .wr     (reg_wr),
    .wr_bits(wr_bits),
    .stat   (reg_rdata)
  );

  // lockout waits for an in-flight transaction, then holds to pulse end
  always_comb lock_d = drv_nxt & (lock_q | ~bus_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else        lock_q <= lock_d;
  end

  assign pin_drive_low = drv_q;
  assign bus_lockout   = lock_q;
endmodule

// File: rtl/sup_rst_gen_chk.sv
module sup_rst_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_ms,
  input logic       supply_low,
  input logic       wdt_early_flt,
  input logic       wdt_late_flt,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       pin_drive_low,
  input logic       bus_lockout
);
  AST_LOCK_ONLY_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lockout |-> pin_drive_low); // R11
  AST_SUPPLY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> pin_drive_low); // R2
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_drive_low) |-> $past(tick_ms)); // R3
  AST_SUPPLY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> reg_rdata[5]); // R8
  AST_EARLY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_early_flt |=> (reg_rdata[7] && pin_drive_low)); // R7
  AST_LATE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_late_flt |=> (reg_rdata[6] && pin_drive_low)); // R7
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4:0] == 5'd0); // R8
  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (&reg_wdata[7:5])) |=>
      ((reg_rdata[7:5] & $past(reg_rdata[7:5])) == $past(reg_rdata[7:5]))); // R9
endmodule

bind sup_rst_gen sup_rst_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_ms      (tick_ms),
  .supply_low   (supply_low),
  .wdt_early_flt(wdt_early_flt),
  .wdt_late_flt (wdt_late_flt),
  .reg_wr       (reg_wr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .pin_drive_low(pin_drive_low),
  .bus_lockout  (bus_lockout)
);

// File: tb/sup_rst_gen_bench.sv
module sup_rst_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 4;
  localparam int WD_CYCLES  = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_ms = 1'b0, supply_low = 1'b0;
  logic       wdt_early_flt = 1'b0, wdt_late_flt = 1'b0;
  logic       bus_busy = 1'b0, reg_wr = 1'b0, ext_low = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       pin_drive_low, bus_lockout, pin_sense;
  int         checks = 0, errors = 0;

  assign pin_sense = ~(pin_drive_low | ext_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  sup_rst_gen #(.HOLD_TICKS(HOLD), .SYNC_STAGES(2)) u_sup_rst_gen (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .supply_low(supply_low),
    .wdt_early_flt(wdt_early_flt), .wdt_late_flt(wdt_late_flt),
    .pin_sense(pin_sense), .bus_busy(bus_busy), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_drive_low(pin_drive_low), .bus_lockout(bus_lockout)
  );

  // write data / expected status after all three flags were set
  localparam logic [15:0] WR_TAB [4] = '{
    {8'hFF, 8'hE0}, {8'hDF, 8'hC0}, {8'h7F, 8'h40}, {8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk) begin reg_wr = 1'b1; reg_wdata = d; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 drive after reset", {7'd0, pin_drive_low}, 8'd1);
    chk("R1 lockout after reset", {7'd0, bus_lockout}, 8'd1);
    chk("R1 status after reset", reg_rdata, 8'h00);
    ticks(HOLD - 1);
    chk("R3 drive before last tick", {7'd0, pin_drive_low}, 8'd1);
    ticks(1);
    chk("R1 drive released", {7'd0, pin_drive_low}, 8'd0);
    chk("R11 lockout released", {7'd0, bus_lockout}, 8'd0);

    // supply low
    @(negedge clk) supply_low = 1'b1;
    @(negedge clk);
    chk("R2 drive on supply low", {7'd0, pin_drive_low}, 8'd1);
    chk("R8 supply flag", reg_rdata, 8'h20);
    ticks(HOLD + 3);
    chk("R2 held while supply low", {7'd0, pin_drive_low}, 8'd1);
    @(negedge clk) supply_low = 1'b0;
    ticks(HOLD - 1);
    chk("R3 stretched after recovery", {7'd0, pin_drive_low}, 8'd1);
    ticks(1);
    chk("R3 released after last tick", {7'd0, pin_drive_low}, 8'd0);
    idle(8);
    chk("R5 no self retrigger", {7'd0, pin_drive_low}, 8'd0);
    write_reg(8'h00);
    chk("R9 cleared", reg_rdata, 8'h00);

    // manual reset, switch held past pulse end
    @(negedge clk) ext_low = 1'b1;
    idle(2);
    chk("R4 not yet after two edges", {7'd0, pin_drive_low}, 8'd0);
    idle(1);
    chk("R4 drive on third edge", {7'd0, pin_drive_low}, 8'd1);
    chk("R11 lockout in manual pulse", {7'd0, bus_lockout}, 8'd1);
    chk("R8 manual sets no flag", reg_rdata, 8'h00);
    ticks(HOLD);
    chk("R6 drive released while held", {7'd0, pin_drive_low}, 8'd0);
    chk("R6 lockout released while held", {7'd0, bus_lockout}, 8'd0);
    idle(6);
    chk("R6 stays released", {7'd0, pin_drive_low}, 8'd0);
    @(negedge clk) ext_low = 1'b0;
    idle(6);
    chk("R5 no trigger on switch release", {7'd0, pin_drive_low}, 8'd0);

    // watchdog faults and restart
    @(negedge clk) wdt_early_flt = 1'b1;
    @(negedge clk) wdt_early_flt = 1'b0;
    chk("R7 early fault drives", {7'd0, pin_drive_low}, 8'd1);
    chk("R7 early flag", reg_rdata, 8'h80);
    ticks(2);
    @(negedge clk) wdt_late_flt = 1'b1;
    @(negedge clk) wdt_late_flt = 1'b0;
    chk("R7 late flag", reg_rdata, 8'hC0);
    ticks(HOLD - 1);
    chk("R10 restart extends pulse", {7'd0, pin_drive_low}, 8'd1);
    ticks(1);
    chk("R10 release after restart", {7'd0, pin_drive_low}, 8'd0);

    // table of clearing writes with all flags set
    @(negedge clk) supply_low = 1'b1;
    @(negedge clk) begin supply_low = 1'b0; wdt_early_flt = 1'b1; end
    @(negedge clk) begin wdt_early_flt = 1'b0; wdt_late_flt = 1'b1; end
    @(negedge clk) wdt_late_flt = 1'b0;
    for (int k = 0; k < 4; k++) begin
      write_reg(WR_TAB[k][15:8]);
      chk("R9 clear by zero bits", reg_rdata, WR_TAB[k][7:0]);
    end
    // set wins over clear
    @(negedge clk) begin wdt_early_flt = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h00; end
    @(negedge clk) begin wdt_early_flt = 1'b0; reg_wr = 1'b0; end
    chk("R9 set beats clear", reg_rdata, 8'h80);
    write_reg(8'h00);
    ticks(HOLD);
    chk("R3 idle before busy test", {7'd0, pin_drive_low}, 8'd0);

    // lockout deferred by busy transaction
    @(negedge clk) begin bus_busy = 1'b1; supply_low = 1'b1; end
    @(negedge clk);
    chk("R11 drive while busy", {7'd0, pin_drive_low}, 8'd1);
    chk("R11 lockout deferred", {7'd0, bus_lockout}, 8'd0);
    @(negedge clk) bus_busy = 1'b0;
    @(negedge clk);
    chk("R11 lockout after busy ends", {7'd0, bus_lockout}, 8'd1);
    @(negedge clk) begin supply_low = 1'b0; bus_busy = 1'b1; end
    idle(2);
    chk("R11 lockout kept once taken", {7'd0, bus_lockout}, 8'd1);
    ticks(HOLD);
    chk("R11 lockout ends with pulse", {7'd0, bus_lockout}, 8'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule